// File: doc/BRIEF.md
# Hardware/Software Owned Clock Gate

This block decides, cycle by cycle, whether a downstream clock may run, and it reports the settled result back through a small control and status register. One register bit hands ownership of the gate either to software, which then sets the gate through an enable bit, or to a hardware request input. The gate output `gate_en` is a clock-enable. A real clock-tree cell is meant to consume it; that cell is not part of this block.

Turning the gate off can be delayed by a programmable hysteresis: a short hold or a long hold, each set in cycles by a parameter. Turning it on is never delayed. If the request comes back during a pending turn-off, the turn-off is cancelled. A separate read-only status bit follows the gate only after the gate has held a new state for a settle interval, so software polls the status bit rather than trusting the enable bit it wrote. A build-time option makes the gate permanently on whatever is written.

Top module: `hs_clock_gate`

## Requirements
- R1: Reset forces `gate_en` and `gate_status` to 0 and clears all control fields, so `csr_rdata` reads 5'b00000 and the hardware request owns the gate.
- R2: With bit 0 (owner) written 1, bit 1 (software enable) drives the gate: `gate_en` follows it on the second rising edge after the write edge (write edge plus one), and `hw_req` has no effect.
- R3: With bit 0 written 0, `hw_req` drives the gate and bit 1 has no effect on `gate_en`. A rise of `hw_req` appears on `gate_en` at the first rising edge that samples it.
- R4: Turn-on is never delayed by hysteresis: `gate_en` rises one edge after the request is seen, whatever bits 2 and 3 hold.
- R5: With bit 2 (hysteresis on) at 0, `gate_en` falls on the first edge that samples the dropped request.
- R6: With bit 2 at 1, `gate_en` falls HOLD_SHORT edges after the request drops when bit 3 (long select) is 0, and HOLD_LONG edges after when bit 3 is 1.
- R7: A request that returns while a turn-off is pending cancels that turn-off. `gate_en` stays 1 and no event is seen on either output.
- R8: `gate_status` (also `csr_rdata[4]`) takes the gate value SETTLE_CYC edges after `gate_en` changes, provided the gate holds that value the whole time. A gate pulse shorter than SETTLE_CYC never shows on the status.
- R9: With KEEP_ON set, `gate_en` is 1 from the first edge after reset, and writing the enable bit as 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | 1 | Hardware request for the clock, used while hardware owns the gate |
| csr_we | input | 1 | Write strobe for the control fields |
| csr_wdata | input | 4 | Write data: bit 0 owner (1 = software), bit 1 software enable, bit 2 hysteresis on, bit 3 long hold |
| csr_rdata | output | 5 | Read data: the four control fields in bits 3:0, the settled status in bit 4 |
| gate_en | output | 1 | Clock-enable for the gated clock |
| gate_status | output | 1 | Settled gate state |

## Verification
The embedded properties assume that `hw_req` and the write port are synchronous to `clk`. They also assume that the hysteresis bits are not rewritten while a turn-off hold is counting, because the hold length is taken from the live register. The stimulus therefore drives every input on the falling edge. It changes the hysteresis fields only while the gate is steady, and it waits out each hold and settle window before starting the next case. The one exception is the cancel case, which rewrites only the enable bit mid-hold.

// File: rtl/hs_clock_gate.sv
module hs_clock_gate #(
  parameter int SETTLE_CYC = 4,
  parameter int HOLD_SHORT = 16,
  parameter int HOLD_LONG  = 64,
  parameter bit KEEP_ON    = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_req,
  input  logic       csr_we,
  input  logic [3:0] csr_wdata,
  output logic [4:0] csr_rdata,
  output logic       gate_en,
  output logic       gate_status
);

  localparam int HCW = $clog2(HOLD_LONG + 1);
  localparam int SCW = $clog2(SETTLE_CYC + 1);

  logic           own_sw, sw_on, hyst_on, hyst_long;
  logic           gate_q, stat_q;
  logic [HCW-1:0] hold_cnt, hold_last;
  logic [SCW-1:0] settle_cnt;
  logic           want;

  always_ff @(posedge clk) begin
    if (rst) {hyst_long, hyst_on, sw_on, own_sw} <= '0;
    else if (csr_we) {hyst_long, hyst_on, sw_on, own_sw} <= csr_wdata;
  end

  assign want = KEEP_ON | (own_sw ? sw_on : hw_req);

  assign hold_last = !hyst_on  ? '0 :
                     hyst_long ? HCW'(HOLD_LONG - 1) : HCW'(HOLD_SHORT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b0;
      hold_cnt <= '0;
    end else if (want) begin
      gate_q   <= 1'b1;
      hold_cnt <= '0;
    end else if (gate_q) begin
      if (hold_cnt >= hold_last) begin
        gate_q   <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q     <= 1'b0;
      settle_cnt <= '0;
    end else if (gate_q == stat_q) begin
      settle_cnt <= '0;
    end else if (settle_cnt == SCW'(SETTLE_CYC - 1)) begin
      stat_q     <= gate_q;
      settle_cnt <= '0;
    end else begin
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign gate_en     = gate_q;
  assign gate_status = stat_q;
  assign csr_rdata   = {stat_q, hyst_long, hyst_on, sw_on, own_sw};

  // R4: a seen request opens a closed gate on the next edge
  assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
    want && !gate_q |=> gate_q);

  // R7: a held or returning request keeps an open gate open
  assert_cancel_R7: assert property (@(posedge clk) disable iff (rst)
    want && gate_q |=> gate_q);

  assert_nohyst_R5: assert property (@(posedge clk) disable iff (rst)
    !want && gate_q && !hyst_on |=> !gate_q);

  assert_short_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !want && gate_q && hyst_on && !hyst_long &&
    (int'(hold_cnt) < HOLD_SHORT - 1) |=> gate_q);

  assert_hw_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !own_sw && !hw_req && !KEEP_ON && !gate_q |=> !gate_q);

  assert_status_lag_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_q) |-> ($past(gate_q) != $past(stat_q)));

  assert_keep_on_R9: assert property (@(posedge clk) disable iff (rst)
    KEEP_ON && gate_q |=> gate_q);

endmodule

// File: tb/hs_clock_gate_test.sv
module hs_clock_gate_test;

  localparam int ST = 4;
  localparam int HS = 16;
  localparam int HL = 64;

  logic       clk = 1'b0;
  logic       rst, hw_req, csr_we;
  logic [3:0] csr_wdata;
  logic [4:0] rdata, rdata_on;
  logic       gate_en, gate_status, en_on, st_on;

  int    cyc = 0;
  int    checks = 0, failures = 0;
  int    expq[$];
  string tagq[$];
  bit    mon_on = 1'b0;
  logic  prev_en, prev_st;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_clock_gate #(.SETTLE_CYC(ST), .HOLD_SHORT(HS), .HOLD_LONG(HL), .KEEP_ON(1'b0)) uut (
    .clk(clk), .rst(rst), .hw_req(hw_req), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(rdata), .gate_en(gate_en), .gate_status(gate_status));

  hs_clock_gate #(.SETTLE_CYC(ST), .HOLD_SHORT(HS), .HOLD_LONG(HL), .KEEP_ON(1'b1)) uut_on (
    .clk(clk), .rst(rst), .hw_req(hw_req), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(rdata_on), .gate_en(en_on), .gate_status(st_on));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input int id, input int v, input string tag);
    expq.push_back(c * 4 + id * 2 + v);
    tagq.push_back(tag);
  endtask

  task automatic take(input int id, input logic v);
    int    e;
    string tag;
    checks++;
    if (expq.size() == 0) begin
      failures++;
      $display("FAIL unexpected event output=%0d actual=%0d expected=none (cycle %0d)", id, v, cyc);
    end else begin
      e   = expq.pop_front();
      tag = tagq.pop_front();
      if (e != cyc * 4 + id * 2 + int'(v)) begin
        failures++;
        $display("FAIL %s actual=out%0d:%0d@%0d expected=out%0d:%0d@%0d",
                 tag, id, v, cyc, (e % 4) / 2, e % 2, e / 4);
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (gate_en !== prev_en) begin
        take(0, gate_en);
        prev_en = gate_en;
      end
      if (gate_status !== prev_st) begin
        take(1, gate_status);
        prev_st = gate_status;
      end
    end
  end

  task automatic wr(input logic [3:0] v, output int t);
    @(negedge clk);
    csr_we = 1'b1;
    csr_wdata = v;
    t = cyc;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic hw(input logic v, output int t);
    @(negedge clk);
    hw_req = v;
    t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t, t2;
    rst = 1'b1; hw_req = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    idle(3);
    check("R1 gate_en", gate_en, 0);
    check("R1 gate_status", gate_status, 0);
    check("R1 csr_rdata", rdata, 0);
    rst = 1'b0;
    prev_en = gate_en;
    prev_st = gate_status;
    mon_on  = 1'b1;

    // hardware ownership, no hysteresis
    hw(1'b1, t); push(t + 1, 0, 1, "R3"); push(t + 1 + ST, 1, 1, "R8");
    idle(10);
    hw(1'b0, t); push(t + 1, 0, 0, "R5"); push(t + 1 + ST, 1, 0, "R8");
    idle(10);

    // hardware ownership, short hold
    wr(4'b0100, t);
    hw(1'b1, t); push(t + 1, 0, 1, "R4"); push(t + 1 + ST, 1, 1, "R8");
    idle(10);
    hw(1'b0, t); push(t + HS, 0, 0, "R6"); push(t + HS + ST, 1, 0, "R8");
    idle(25);

    // enable bit ignored under hardware ownership
    wr(4'b0010, t);
    idle(10);
    check("R3 enable ignored", gate_en, 0);
    check("R3 csr_rdata", rdata, 5'b00010);

    // software ownership
    wr(4'b0011, t); push(t + 2, 0, 1, "R2"); push(t + 2 + ST, 1, 1, "R8");
    idle(8);
    check("R8 status readback", rdata[4], 1);
    wr(4'b0001, t); push(t + 2, 0, 0, "R5"); push(t + 2 + ST, 1, 0, "R8");
    idle(8);

    // handover between owners
    hw(1'b1, t);
    idle(5);
    check("R2 hw_req ignored", gate_en, 0);
    wr(4'b0000, t); push(t + 2, 0, 1, "R3"); push(t + 2 + ST, 1, 1, "R8");
    idle(8);
    wr(4'b0001, t); push(t + 2, 0, 0, "R2"); push(t + 2 + ST, 1, 0, "R8");
    idle(8);
    hw(1'b0, t);
    idle(3);

    // short hold under software
    wr(4'b0111, t); push(t + 2, 0, 1, "R4"); push(t + 2 + ST, 1, 1, "R8");
    idle(10);
    wr(4'b0101, t); push(t + 1 + HS, 0, 0, "R6"); push(t + 1 + HS + ST, 1, 0, "R8");
    idle(25);

    // long hold
    wr(4'b1111, t); push(t + 2, 0, 1, "R4"); push(t + 2 + ST, 1, 1, "R8");
    idle(10);
    wr(4'b1101, t); push(t + 1 + HL, 0, 0, "R6"); push(t + 1 + HL + ST, 1, 0, "R8");
    idle(75);

    // cancel a pending turn-off
    wr(4'b1111, t); push(t + 2, 0, 1, "R4"); push(t + 2 + ST, 1, 1, "R8");
    idle(10);
    wr(4'b1101, t);
    idle(20);
    wr(4'b1111, t);
    idle(80);
    check("R7 gate kept", gate_en, 1);
    check("R7 status kept", gate_status, 1);
    wr(4'b0001, t); push(t + 2, 0, 0, "R5"); push(t + 2 + ST, 1, 0, "R8");
    idle(8);

    // pulse shorter than settle never reaches status
    wr(4'b0000, t);
    hw(1'b1, t); push(t + 1, 0, 1, "R3");
    hw(1'b0, t2); push(t2 + 1, 0, 0, "R8");
    idle(10);
    check("R8 short pulse hidden", gate_status, 0);

    // always-on build
    check("R9 keep on", en_on, 1);
    check("R9 keep on status", st_on, 1);
    wr(4'b0001, t);
    idle(5);
    check("R9 disable ignored", en_on, 1);

    idle(20);
    check("R8 no pending events", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule